// File: doc/BRIEF.md
# Uni-directional weighted prediction datapath

This block turns a stream of signed 16-bit intermediate-precision prediction samples into saturated 8-bit pixels for video inter prediction. Each sample has a level shift added, is scaled by a signed weight, is rounded and arithmetically right-shifted, and then has an offset added. The level shift, offset and rounding term are merged into one 32-bit constant when a block is started. After that, each sample costs one multiply, one add and one shift. Two saturation stages follow: first to unsigned 16 bits, then to unsigned 8 bits.

A start pulse captures the weight, offset, shift, level shift, block width and block height. Samples then enter on a valid/ready stream, pass through a three-stage pipeline that stalls as a unit, and leave on a valid/ready stream. Each output sample carries its column and row. Samples are expected, and emitted, in 4x4 tiles: four samples per row inside a tile, four rows per tile, tiles from left to right, and tile rows from top to bottom. A done pulse marks the end of a block.

Top module: `wpred_uni`

## Requirements
- R1: Each output pixel equals ((src + lvl) * wgt + (1 << (shift - 1))) >> shift, plus off, clamped to the range 0..255. The right shift is arithmetic, `src`, `wgt` and `lvl` are signed 16-bit values, and `off` is a signed 16-bit value.
- R2: The product of sample and weight is kept at full signed 32-bit width, including the case src = -32768 with wgt = -32768.
- R3: Any result below zero produces a pixel of 0.
- R4: Any result above 255 produces a pixel of 255, including results above 65535.
- R5: Outputs carry `out_col_o`/`out_row_o` coordinates, and the n-th output (counting from 0) has the following position. The tile index is n/16 and the position inside the tile is n%16. The tile's column origin is 4*(tile % (width/4)) and its row origin is 4*(tile / (width/4)). The column is the column origin plus (n%16)%4, and the row is the row origin plus (n%16)/4.
- R6: A start with width 0 or height 0 raises `done_o` for one cycle in the cycle after the start. No sample is accepted and no output is produced.
- R7: A start whose nonzero width or height is not a multiple of 4, or whose shift is 0, sets `cfg_err_o` from the next cycle. `cfg_err_o` then holds until the next start, and the block stays idle, accepting no samples. A good start clears it.
- R8: While `out_valid_o` is high and `out_ready_i` is low, `out_data_o`, `out_col_o` and `out_row_o` hold their values and `out_valid_o` stays high.
- R9: `done_o` pulses for one cycle in the cycle after the last output of a block is accepted. In that cycle `in_ready_o` and `out_valid_o` are low.
- R10: After reset, `out_valid_o`, `in_ready_o`, `done_o` and `cfg_err_o` are all low.
- R11: After a good start, `in_ready_o` can be high. The block accepts exactly width*height samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; captures the configuration when idle |
| wgt_i | input | 16 | Signed weight |
| off_i | input | 16 | Signed offset added after the shift |
| shift_i | input | SHIFT_W | Right shift amount, at least 1 |
| lvl_i | input | 16 | Signed level shift added to each sample |
| width_i | input | DIM_W | Block width in samples |
| height_i | input | DIM_W | Block height in samples |
| cfg_err_o | output | 1 | Last start was rejected |
| done_o | output | 1 | One-cycle end-of-block pulse |
| in_valid_i | input | 1 | Input sample valid |
| in_ready_o | output | 1 | Input sample accepted when valid |
| in_data_i | input | 16 | Signed input sample |
| out_valid_o | output | 1 | Output pixel valid |
| out_ready_i | input | 1 | Downstream accepts the pixel |
| out_data_o | output | 8 | Saturated pixel |
| out_col_o | output | DIM_W | Column of the pixel |
| out_row_o | output | DIM_W | Row of the pixel |

## Verification
The assertions take for granted that no start is issued while the block is running. They also assume that the configured terms stay within signed 32-bit range, so that the merged constant equals the level-shifted form. The stimulus table keeps every weight, level shift, offset and shift inside that range, and it issues each start only after the previous done or error has been observed. Each run applies irregular input gaps and output back-pressure, so stalls occur both in the middle of a tile and on its last sample.

// File: rtl/wpred_pkg.sv
package wpred_pkg;
  localparam int SAMPLE_W = 16;
  localparam int PIX_W    = 8;
  localparam int ACC_W    = 32;
  localparam int TILE     = 4;
  localparam int TILE_LG  = 2;
  localparam int MID_W    = 16;

  // two-stage clamp: signed acc -> unsigned mid -> unsigned pixel
  function automatic logic [PIX_W-1:0] sat_pix(input logic signed [ACC_W-1:0] v);
    logic [MID_W-1:0] u;
    if (v < 0)
      u = '0;
    else if (v > $signed({{(ACC_W-MID_W){1'b0}}, {MID_W{1'b1}}}))
      u = '1;
    else
      u = v[MID_W-1:0];
    if (u > {{(MID_W-PIX_W){1'b0}}, {PIX_W{1'b1}}})
      return '1;
    return u[PIX_W-1:0];
  endfunction
endpackage

// File: rtl/wpred_cfg.sv
module wpred_cfg
  import wpred_pkg::*;
#(
  parameter int DIM_W   = 12,
  parameter int SHIFT_W = 5
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic                       idle_i,
  input  logic [SAMPLE_W-1:0]        wgt_i,
  input  logic [SAMPLE_W-1:0]        off_i,
  input  logic [SHIFT_W-1:0]         shift_i,
  input  logic [SAMPLE_W-1:0]        lvl_i,
  input  logic [DIM_W-1:0]           width_i,
  input  logic [DIM_W-1:0]           height_i,
  output logic                       go_o,
  output logic                       empty_o,
  output logic                       err_o,
  output logic [SAMPLE_W-1:0]        wgt_o,
  output logic [SHIFT_W-1:0]         shift_o,
  output logic signed [ACC_W-1:0]    k_o,
  output logic [DIM_W-1:0]           width_o,
  output logic [DIM_W-1:0]           height_o
);
  localparam int EXT = ACC_W - SAMPLE_W;

  logic req, zero, bad;
  logic signed [ACC_W-1:0] lvl_x, wgt_x, off_x, rnd, k_nxt;

  assign req     = start_i && idle_i;
  assign zero    = (width_i == '0) || (height_i == '0);
  assign bad     = (width_i[TILE_LG-1:0] != '0) || (height_i[TILE_LG-1:0] != '0) ||
                   (shift_i == '0);
  assign go_o    = req && !zero && !bad;
  assign empty_o = req && zero;

  always_comb begin
    lvl_x = {{EXT{lvl_i[SAMPLE_W-1]}}, lvl_i};
    wgt_x = {{EXT{wgt_i[SAMPLE_W-1]}}, wgt_i};
    off_x = {{EXT{off_i[SAMPLE_W-1]}}, off_i};
    rnd   = '0;
    rnd[shift_i - 1'b1] = 1'b1;
    // level shift, offset and rounding merged into one constant
    k_nxt = lvl_x * wgt_x + (off_x <<< shift_i) + rnd;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o    <= 1'b0;
      wgt_o    <= '0;
      shift_o  <= '0;
      k_o      <= '0;
      width_o  <= '0;
      height_o <= '0;
    end else if (req) begin
      err_o <= !zero && bad;
      if (go_o) begin
        wgt_o    <= wgt_i;
        shift_o  <= shift_i;
        k_o      <= k_nxt;
        width_o  <= width_i;
        height_o <= height_i;
      end
    end
  end
endmodule

// File: rtl/wpred_pipe.sv
module wpred_pipe
  import wpred_pkg::*;
#(
  parameter int SHIFT_W = 5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    adv_i,
  input  logic                    in_valid_i,
  input  logic [SAMPLE_W-1:0]     in_data_i,
  input  logic [SAMPLE_W-1:0]     wgt_i,
  input  logic signed [ACC_W-1:0] k_i,
  input  logic [SHIFT_W-1:0]      shift_i,
  output logic                    out_valid_o,
  output logic [PIX_W-1:0]        out_data_o
);
  localparam int EXT = ACC_W - SAMPLE_W;

  logic                    v1_q, v2_q;
  logic signed [ACC_W-1:0] p1_q, s2_q;
  logic signed [ACC_W-1:0] src_x, wgt_x, sum2;

  assign src_x = {{EXT{in_data_i[SAMPLE_W-1]}}, in_data_i};
  assign wgt_x = {{EXT{wgt_i[SAMPLE_W-1]}}, wgt_i};
  assign sum2  = p1_q + k_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q        <= 1'b0;
      v2_q        <= 1'b0;
      out_valid_o <= 1'b0;
      p1_q        <= '0;
      s2_q        <= '0;
      out_data_o  <= '0;
    end else if (adv_i) begin
      v1_q        <= in_valid_i;
      p1_q        <= src_x * wgt_x;
      v2_q        <= v1_q;
      s2_q        <= sum2 >>> shift_i;
      out_valid_o <= v2_q;
      out_data_o  <= sat_pix(s2_q);
    end
  end
endmodule

// File: rtl/wpred_scan.sv
module wpred_scan
  import wpred_pkg::*;
#(
  parameter int DIM_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic [DIM_W-1:0] width_i,
  input  logic [DIM_W-1:0] height_i,
  output logic [DIM_W-1:0] col_o,
  output logic [DIM_W-1:0] row_o,
  output logic             last_o
);
  localparam logic [DIM_W-1:0]   STEP = DIM_W'(TILE);
  localparam logic [TILE_LG-1:0] EDGE = '1;

  logic [DIM_W-1:0]   bx_q, by_q;
  logic [TILE_LG-1:0] c_q, r_q;
  logic               row_end;

  assign row_end = (bx_q + STEP == width_i);
  assign last_o  = (c_q == EDGE) && (r_q == EDGE) && row_end && (by_q + STEP == height_i);
  assign col_o   = bx_q + DIM_W'(c_q);
  assign row_o   = by_q + DIM_W'(r_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bx_q <= '0;
      by_q <= '0;
      c_q  <= '0;
      r_q  <= '0;
    end else if (clear_i) begin
      bx_q <= '0;
      by_q <= '0;
      c_q  <= '0;
      r_q  <= '0;
    end else if (step_i) begin
      if (c_q != EDGE) begin
        c_q <= c_q + 1'b1;
      end else begin
        c_q <= '0;
        if (r_q != EDGE) begin
          r_q <= r_q + 1'b1;
        end else begin
          r_q <= '0;
          if (row_end) begin
            bx_q <= '0;
            by_q <= by_q + STEP;
          end else begin
            bx_q <= bx_q + STEP;
          end
        end
      end
    end
  end
endmodule

// File: rtl/wpred_uni.sv
module wpred_uni
  import wpred_pkg::*;
#(
  parameter int DIM_W   = 12,
  parameter int SHIFT_W = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [SAMPLE_W-1:0] wgt_i,
  input  logic [SAMPLE_W-1:0] off_i,
  input  logic [SHIFT_W-1:0]  shift_i,
  input  logic [SAMPLE_W-1:0] lvl_i,
  input  logic [DIM_W-1:0]    width_i,
  input  logic [DIM_W-1:0]    height_i,
  output logic                cfg_err_o,
  output logic                done_o,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  input  logic [SAMPLE_W-1:0] in_data_i,
  output logic                out_valid_o,
  input  logic                out_ready_i,
  output logic [PIX_W-1:0]    out_data_o,
  output logic [DIM_W-1:0]    out_col_o,
  output logic [DIM_W-1:0]    out_row_o
);
  localparam int CNT_W = 2 * DIM_W;

  logic                    go, empty, run_q, adv, in_fire, out_fire, last;
  logic [SAMPLE_W-1:0]     wgt_q;
  logic [SHIFT_W-1:0]      shift_q;
  logic signed [ACC_W-1:0] k_q;
  logic [DIM_W-1:0]        width_q, height_q;
  logic [CNT_W-1:0]        in_left_q;

  wpred_cfg #(.DIM_W(DIM_W), .SHIFT_W(SHIFT_W)) i_cfg (
    .clk_i, .rst_ni, .start_i, .idle_i(!run_q),
    .wgt_i, .off_i, .shift_i, .lvl_i, .width_i, .height_i,
    .go_o(go), .empty_o(empty), .err_o(cfg_err_o),
    .wgt_o(wgt_q), .shift_o(shift_q), .k_o(k_q),
    .width_o(width_q), .height_o(height_q)
  );

  assign adv        = !(out_valid_o && !out_ready_i);
  assign in_ready_o = run_q && (in_left_q != '0) && adv;
  assign in_fire    = in_valid_i && in_ready_o;
  assign out_fire   = out_valid_o && out_ready_i;

  wpred_pipe #(.SHIFT_W(SHIFT_W)) i_pipe (
    .clk_i, .rst_ni, .adv_i(adv),
    .in_valid_i(in_fire), .in_data_i,
    .wgt_i(wgt_q), .k_i(k_q), .shift_i(shift_q),
    .out_valid_o, .out_data_o
  );

  wpred_scan #(.DIM_W(DIM_W)) i_scan (
    .clk_i, .rst_ni, .clear_i(go), .step_i(out_fire),
    .width_i(width_q), .height_i(height_q),
    .col_o(out_col_o), .row_o(out_row_o), .last_o(last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b0;
      done_o    <= 1'b0;
      in_left_q <= '0;
    end else begin
      done_o <= empty || (out_fire && last);
      if (go) begin
        run_q     <= 1'b1;
        in_left_q <= CNT_W'(width_i) * CNT_W'(height_i);
      end else begin
        if (out_fire && last) run_q <= 1'b0;
        if (in_fire) in_left_q <= in_left_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/wpred_uni_chk.sv
module wpred_uni_chk #(
  parameter int DIM_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [7:0]       out_data_o,
  input logic [DIM_W-1:0] out_col_o,
  input logic [DIM_W-1:0] out_row_o,
  input logic             done_o,
  input logic             in_ready_o,
  input logic             cfg_err_o,
  input logic             run_q,
  input logic [DIM_W-1:0] width_q,
  input logic [DIM_W-1:0] height_q
);
  // R8
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o) &&
                                       $stable(out_col_o) && $stable(out_row_o)));
  // R9
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!out_valid_o && !in_ready_o));
  // R5
  coord_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_col_o < width_q && out_row_o < height_q));
  // R7
  err_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> !run_q);
  // R11
  out_in_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> run_q);
endmodule

bind wpred_uni wpred_uni_chk #(.DIM_W(DIM_W)) i_wpred_uni_chk (.*);

// File: tb/test_wpred_uni.sv
module test_wpred_uni;
  localparam int DIM_W = 12;
  localparam int SHIFT_W = 5;

  typedef struct packed {
    logic [15:0] wgt;
    logic [15:0] off;
    logic [4:0]  sh;
    logic [15:0] lvl;
    logic [11:0] w;
    logic [11:0] h;
    logic [15:0] seed;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{16'd64,     16'd0,     5'd12, 16'd8192,  12'd4, 12'd4, 16'd3},
    '{-16'sd20,   16'd10,    5'd7,  16'd8192,  12'd4, 12'd4, 16'd11},
    '{16'd200,    -16'sd50,  5'd9,  16'd0,     12'd4, 12'd4, 16'd29},
    '{16'h8000,   16'd0,     5'd20, 16'd0,     12'd8, 12'd4, 16'd0},
    '{16'd1,      16'd127,   5'd1,  -16'sd100, 12'd4, 12'd8, 16'd47},
    '{16'd37,     -16'sd128, 5'd14, 16'd4000,  12'd8, 12'd8, 16'd5}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [15:0] wgt = '0, off = '0, lvl = '0;
  logic [SHIFT_W-1:0] sh = '0;
  logic [DIM_W-1:0] wd = '0, ht = '0;
  logic cfg_err, done, in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1;
  logic [15:0] in_data = '0;
  logic [7:0] out_data;
  logic [DIM_W-1:0] out_col, out_row;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  wpred_uni #(.DIM_W(DIM_W), .SHIFT_W(SHIFT_W)) i_wpred_uni (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .wgt_i(wgt), .off_i(off), .shift_i(sh), .lvl_i(lvl),
    .width_i(wd), .height_i(ht), .cfg_err_o(cfg_err), .done_o(done),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .out_col_o(out_col), .out_row_o(out_row)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] src_of(input int k, input int seed);
    int t;
    t = (k * 7919 + seed * 131 + 12345) & 16'hFFFF;
    return t[15:0];
  endfunction

  function automatic longint model(input logic [15:0] s, input vec_t v);
    longint x;
    x = ((longint'($signed(s)) + longint'($signed(v.lvl))) * longint'($signed(v.wgt))
         + (longint'(1) <<< (v.sh - 1))) >>> v.sh;
    x = x + longint'($signed(v.off));
    if (x < 0) x = 0;
    if (x > 65535) x = 65535;
    if (x > 255) x = 255;
    return x;
  endfunction

  task automatic do_start(input vec_t v);
    @(negedge clk);
    wgt = v.wgt; off = v.off; sh = v.sh; lvl = v.lvl; wd = v.w; ht = v.h;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_block(input vec_t v, input int idx);
    int total;
    total = int'(v.w) * int'(v.h);
    do_start(v);
    // R11 accepting right after a good start
    chk(in_ready == 1'b1, "R11", in_ready, 1);
    chk(cfg_err == 1'b0, "R7", cfg_err, 0);
    fork
      begin : producer
        for (int k = 0; k < total; k++) begin
          if ((k + idx) % 5 == 4) begin
            in_valid = 1'b0;
            @(negedge clk);
          end
          in_valid = 1'b1;
          in_data = src_of(k, v.seed);
          forever begin
            #4;
            if (in_ready) begin
              @(posedge clk);
              break;
            end
            @(negedge clk);
          end
          @(negedge clk);
        end
        in_valid = 1'b0;
      end
      begin : consumer
        int got, cyc, tile, pos, tpr;
        bit hold;
        logic [7:0] hd;
        logic [DIM_W-1:0] hc, hr;
        longint e;
        string tag;
        got = 0; cyc = 0; hold = 0;
        tpr = int'(v.w) / 4;
        while (got < total) begin
          @(negedge clk);
          out_ready = (idx % 2 == 1) ? ((cyc % 3) != 1) : ((cyc % 7) != 5);
          cyc++;
          #4;
          if (hold)
            chk(out_valid && out_data == hd && out_col == hc && out_row == hr,
                "R8", {out_data, out_col}, {hd, hc});
          hold = out_valid && !out_ready;
          hd = out_data; hc = out_col; hr = out_row;
          if (out_valid && out_ready) begin
            e = model(src_of(got, v.seed), v);
            if (v.wgt == 16'h8000) tag = "R2";
            else if (e == 0) tag = "R3";
            else if (e == 255) tag = "R4";
            else tag = "R1";
            chk(longint'(out_data) == e, tag, out_data, e);
            tile = got / 16; pos = got % 16;
            chk(int'(out_col) == (tile % tpr) * 4 + pos % 4, "R5", out_col, (tile % tpr) * 4 + pos % 4);
            chk(int'(out_row) == (tile / tpr) * 4 + pos / 4, "R5", out_row, (tile / tpr) * 4 + pos / 4);
            got++;
          end
        end
      end
    join
    out_ready = 1'b1;
    in_valid = 1'b1;
    @(negedge clk);
    // R9 done pulse one cycle after the last output handshake
    chk(done == 1'b1, "R9", done, 1);
    chk(in_ready == 1'b0 && out_valid == 1'b0, "R9", {in_ready, out_valid}, 0);
    @(negedge clk);
    chk(done == 1'b0, "R9", done, 0);
    // R11 no extra sample taken after width*height
    chk(in_ready == 1'b0, "R11", in_ready, 0);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    vec_t z;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(out_valid == 1'b0, "R10", out_valid, 0);
    chk(in_ready == 1'b0, "R10", in_ready, 0);
    chk(done == 1'b0 && cfg_err == 1'b0, "R10", {done, cfg_err}, 0);

    for (int i = 0; i < 6; i++) run_block(VEC[i], i);

    // R6 zero width
    z = VEC[0]; z.w = '0; z.h = 12'd8;
    in_valid = 1'b1;
    do_start(z);
    chk(done == 1'b1, "R6", done, 1);
    chk(in_ready == 1'b0 && out_valid == 1'b0, "R6", {in_ready, out_valid}, 0);
    @(negedge clk);
    chk(done == 1'b0 && out_valid == 1'b0, "R6", {done, out_valid}, 0);
    // R6 zero height
    z.w = 12'd4; z.h = '0;
    do_start(z);
    chk(done == 1'b1 && cfg_err == 1'b0, "R6", {done, cfg_err}, 2);

    // R7 width not a multiple of 4
    z = VEC[1]; z.w = 12'd6;
    do_start(z);
    chk(cfg_err == 1'b1, "R7", cfg_err, 1);
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b0 && out_valid == 1'b0 && done == 1'b0, "R7",
        {in_ready, out_valid, done}, 0);
    chk(cfg_err == 1'b1, "R7", cfg_err, 1);
    // R7 shift of zero
    z = VEC[1]; z.sh = '0;
    do_start(z);
    chk(cfg_err == 1'b1 && in_ready == 1'b0, "R7", {cfg_err, in_ready}, 2);
    in_valid = 1'b0;

    // good start clears the error
    run_block(VEC[2], 2);
    chk(cfg_err == 1'b0, "R7", cfg_err, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule